// File: doc/BRIEF.md
# Island ID address decoder

This block works out which island a fabric bus request is headed for, starting from the request's 40-bit address. It takes a translation mode, a flag that says whether the address uses the wide 40-bit layout or the narrow 32-bit layout, and two 6-bit base island numbers. The mode sets how the island is found:

- Mode 0 lifts the island straight out of an address field.
- Mode 1 uses one index bit of the address to pick one of the two bases.
- Modes 2 and 3 pick a base the same way. They then clear one or two low bits of that base and fill them from the address bits just under the index bit.

A request is made with a one-cycle `req` pulse. One cycle later `done` pulses, and the island number and the error flag appear. Those two outputs stay as they are until the next request. The block reports an error for two target codes it does not decode, and for any mode value above 3. It does not check whether the island it produces exists.

Top module: `iid_decoder`

## Requirements
- R1: In mode 0 the island is addr[39:34] when `wide` is 1, and addr[31:26] when `wide` is 0.
- R2: In mode 1 the index bit is addr[39] (wide) or addr[31] (narrow). The island is `base1` when the index bit is 1, and `base0` when it is 0.
- R3: In mode 2 the base is chosen by the index bit with its bit 0 cleared. Island bit 0 is then the address bit one below the index bit: addr[38] (wide) or addr[30] (narrow).
- R4: In mode 3 the base is chosen by the index bit with bits 1:0 cleared. Island bit 1 is the address bit one below the index bit, and island bit 0 is the address bit two below it: addr[38:37] (wide) or addr[30:29] (narrow).
- R5: A request whose target code is 7 (memory unit) or 14 (cluster register bus) sets `err`, whatever the mode. Every other target code, 0 to 15, is decoded normally.
- R6: A request whose mode value is 4, 5, 6 or 7 sets `err`.
- R7: `done` is 1 in exactly the cycle after a cycle in which `req` was 1, and is 0 in every other cycle.
- R8: Whenever `err` is 1, `island` is 0.
- R9: Between requests, `island` and `err` keep their last values, whatever the other inputs do.
- R10: A synchronous reset, with `rst_n` low, clears `done`, `err` and `island` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | One-cycle request strobe |
| addr | input | 40 | Fabric bus address |
| tgt | input | 4 | Target code |
| mode | input | 3 | Translation mode; 0 to 3 are valid |
| wide | input | 1 | 1 selects the 40-bit address layout, 0 the 32-bit layout |
| base0 | input | 6 | Base island chosen when the index bit is 0 |
| base1 | input | 6 | Base island chosen when the index bit is 1 |
| done | output | 1 | Result-valid pulse, one cycle after `req` |
| island | output | 6 | Decoded island number, 0 when `err` is 1 |
| err | output | 1 | Request cannot be decoded |

## Verification
The bench uses odd and all-ones base islands in modes 2 and 3. A design that forgot to clear the base's low bits would OR them with the address bits and return the wrong island. The bench flips the `wide` flag while keeping the same address pattern. A design that took the wrong index or field position would return the other layout's island. It sends the two excluded target codes and the modes above 3 with otherwise valid fields, and expects `err` with island 0. A design that leaked the decoded value, or dropped the error check, would show a nonzero island. It also changes the inputs between requests, to catch outputs that follow the inputs instead of holding the last result.

// File: rtl/iid_pkg.sv
// Shared widths, target codes and mode encodings for the island ID decoder.
package iid_pkg;
    localparam int IID_ADDR_W = 40;
    localparam int IID_ISL_W  = 6;
    localparam int IID_TGT_W  = 4;
    localparam int IID_MODE_W = 3;

    // Target codes that this decoder refuses.
    localparam logic [IID_TGT_W-1:0] IID_TGT_MEMUNIT = 4'd7;
    localparam logic [IID_TGT_W-1:0] IID_TGT_REGBUS  = 4'd14;

    typedef enum logic [IID_MODE_W-1:0] {
        IID_MODE_FIELD  = 3'd0,
        IID_MODE_PAIR   = 3'd1,
        IID_MODE_SPLIT1 = 3'd2,
        IID_MODE_SPLIT2 = 3'd3
    } iid_mode_e;

    typedef struct packed {
        logic                 err;
        logic [IID_ISL_W-1:0] island;
    } iid_result_t;
endpackage

// File: rtl/iid_field_pick.sv
// Takes from the address the bits that every mode needs: the island field,
// the index bit, and the bits just under the index bit.
// Assumes: the wide and narrow positions lie inside the address, and
// SPLICE_W does not exceed the index bit position.
module iid_field_pick #(
    parameter int ADDR_W       = iid_pkg::IID_ADDR_W,
    parameter int ISL_W        = iid_pkg::IID_ISL_W,
    parameter int SPLICE_W     = 2,
    parameter int WIDE_FLD_LSB = 34,
    parameter int NARR_FLD_LSB = 26,
    parameter int WIDE_IDX     = 39,
    parameter int NARR_IDX     = 31
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wide,
    output logic [ISL_W-1:0]    field,
    output logic                idx,
    output logic [SPLICE_W-1:0] below
);
    // Choose between the wide and narrow bit positions.
    always_comb begin
        if (wide) begin
            field = addr[WIDE_FLD_LSB +: ISL_W];
            idx   = addr[WIDE_IDX];
            below = addr[WIDE_IDX-1 -: SPLICE_W];
        end else begin
            field = addr[NARR_FLD_LSB +: ISL_W];
            idx   = addr[NARR_IDX];
            below = addr[NARR_IDX-1 -: SPLICE_W];
        end
    end
endmodule

// File: rtl/iid_mode_mux.sv
// Builds one candidate island for each mode and returns the one the mode
// selects. A candidate that splices k bits clears the k low bits of the
// chosen base and puts in the top k bits of `below`.
// Assumes: mode 0 is the field mode, and modes 1..SPLICE_W+1 splice
// 0..SPLICE_W bits. Any other mode value is flagged as not valid.
module iid_mode_mux #(
    parameter int ISL_W    = iid_pkg::IID_ISL_W,
    parameter int MODE_W   = iid_pkg::IID_MODE_W,
    parameter int SPLICE_W = 2
) (
    input  logic [MODE_W-1:0]   mode,
    input  logic [ISL_W-1:0]    field,
    input  logic                idx,
    input  logic [SPLICE_W-1:0] below,
    input  logic [ISL_W-1:0]    base0,
    input  logic [ISL_W-1:0]    base1,
    output logic [ISL_W-1:0]    island,
    output logic                mode_ok
);
    localparam int NCAND = SPLICE_W + 1;

    logic [ISL_W-1:0] base;
    logic [ISL_W-1:0] cand [NCAND];

    // Pick a base island with the index bit.
    always_comb base = idx ? base1 : base0;

    // One candidate for each splice width.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        if (k == 0) begin : g_plain
            assign cand[k] = base;
        end else begin : g_splice
            assign cand[k] = {base[ISL_W-1:k], below[SPLICE_W-1 -: k]};
        end
    end

    // Select by mode; a mode out of range gives zero and mode_ok = 0.
    always_comb begin
        island  = '0;
        mode_ok = 1'b0;
        if (mode == MODE_W'(iid_pkg::IID_MODE_FIELD)) begin
            island  = field;
            mode_ok = 1'b1;
        end
        for (int m = 1; m <= NCAND; m++) begin
            if (mode == MODE_W'(m)) begin
                island  = cand[m-1];
                mode_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iid_decoder.sv
// Island ID decoder top. It decodes without a clock, then registers the
// result and a done pulse on each request strobe.
// Assumes: req is sampled on every rising edge; rst_n is synchronous and
// active low.
module iid_decoder #(
    parameter int ADDR_W   = iid_pkg::IID_ADDR_W,
    parameter int ISL_W    = iid_pkg::IID_ISL_W,
    parameter int TGT_W    = iid_pkg::IID_TGT_W,
    parameter int MODE_W   = iid_pkg::IID_MODE_W,
    parameter int SPLICE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TGT_W-1:0]  tgt,
    input  logic [MODE_W-1:0] mode,
    input  logic              wide,
    input  logic [ISL_W-1:0]  base0,
    input  logic [ISL_W-1:0]  base1,
    output logic              done,
    output logic [ISL_W-1:0]  island,
    output logic              err
);
    logic [ISL_W-1:0]    fld;
    logic                idx_bit;
    logic [SPLICE_W-1:0] low_bits;
    logic [ISL_W-1:0]    cand_island;
    logic                mode_ok;
    logic                tgt_ok;
    logic                bad;

    iid_field_pick #(
        .ADDR_W(ADDR_W), .ISL_W(ISL_W), .SPLICE_W(SPLICE_W)
    ) u_pick (
        .addr(addr), .wide(wide), .field(fld), .idx(idx_bit), .below(low_bits)
    );

    iid_mode_mux #(
        .ISL_W(ISL_W), .MODE_W(MODE_W), .SPLICE_W(SPLICE_W)
    ) u_mux (
        .mode(mode), .field(fld), .idx(idx_bit), .below(low_bits),
        .base0(base0), .base1(base1), .island(cand_island), .mode_ok(mode_ok)
    );

    // Reject the targets that this decoder does not handle.
    always_comb tgt_ok = (tgt != iid_pkg::IID_TGT_MEMUNIT) &&
                         (tgt != iid_pkg::IID_TGT_REGBUS);

    // Combine the two error sources.
    always_comb bad = !(tgt_ok && mode_ok);

    // Capture the result on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            err    <= 1'b0;
            island <= '0;
        end else begin
            done <= req;
            if (req) begin
                err    <= bad;
                island <= bad ? '0 : cand_island;
            end
        end
    end

    a_r7_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);
    a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done);
    a_r8_err_zero_island: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (island == '0));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(island) && $stable(err)));
    a_r5_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (tgt == iid_pkg::IID_TGT_MEMUNIT || tgt == iid_pkg::IID_TGT_REGBUS)) |=> err);
    a_r6_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode > MODE_W'(3)) |=> err);
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && island == '0));
endmodule

// File: tb/iid_decoder_tb.sv
module iid_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [39:0] addr = '0;
    logic [3:0]  tgt = '0;
    logic [2:0]  mode = '0;
    logic        wide = 1'b0;
    logic [5:0]  base0 = '0;
    logic [5:0]  base1 = '0;
    logic        done;
    logic [5:0]  island;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    iid_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .tgt(tgt),
        .mode(mode), .wide(wide), .base0(base0), .base1(base1),
        .done(done), .island(island), .err(err)
    );

    // Reference model written from the requirements: returns {err, island}.
    function automatic logic [6:0] model(logic [39:0] a, logic [3:0] t, logic [2:0] m,
                                         logic w, logic [5:0] b0, logic [5:0] b1);
        int ix = w ? 39 : 31;
        logic [5:0] b = a[ix] ? b1 : b0;
        if (t == 4'd7 || t == 4'd14 || m > 3'd3) return 7'h40;  // R5, R6, R8
        case (m)
            3'd0: return {1'b0, (w ? a[39:34] : a[31:26])};          // R1
            3'd1: return {1'b0, b};                                  // R2
            3'd2: return {1'b0, b[5:1], a[ix-1]};                    // R3
            default: return {1'b0, b[5:2], a[ix-1], a[ix-2]};        // R4
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One request; checks done, err and island in the cycle after req.
    task automatic issue(string tag, logic [39:0] a, logic [3:0] t, logic [2:0] m,
                         logic w, logic [5:0] b0, logic [5:0] b1);
        logic [6:0] e = model(a, t, m, w, b0, b1);
        @(negedge clk);
        addr = a; tgt = t; mode = m; wide = w; base0 = b0; base1 = b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check({tag, " (R7 done)"}, {7'd0, done}, 8'd1);
        check(tag, {1'b0, err, island}, {1'b0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [6:0] last;
        process::self().srandom(32'h1D5EED);
        repeat (3) @(negedge clk);
        check("R10 reset state", {done, err, island}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle done low", {7'd0, done}, 8'd0);

        // Directed cases.
        issue("R1 narrow field", 40'h00_A800_0000, 4'd0, 3'd0, 1'b0, 6'd0, 6'd0);
        issue("R1 wide field",   40'h54_0000_0000, 4'd0, 3'd0, 1'b1, 6'd0, 6'd0);
        issue("R1 wide ignores narrow", 40'h00_FC00_0000, 4'd1, 3'd0, 1'b1, 6'd0, 6'd0);
        issue("R2 narrow idx1",  40'h00_8000_0000, 4'd3, 3'd1, 1'b0, 6'd5, 6'd42);
        issue("R2 narrow idx0",  40'h00_7FFF_FFFF, 4'd3, 3'd1, 1'b0, 6'd5, 6'd42);
        issue("R2 wide idx1",    40'h80_0000_0000, 4'd3, 3'd1, 1'b1, 6'd5, 6'd42);
        issue("R3 odd base cleared", 40'h00_4000_0000, 4'd2, 3'd2, 1'b0, 6'd33, 6'd63);
        issue("R3 wide idx1",    40'hC0_0000_0000, 4'd2, 3'd2, 1'b1, 6'd33, 6'd63);
        issue("R3 low bit zero", 40'h00_8000_0000, 4'd2, 3'd2, 1'b0, 6'd33, 6'd63);
        issue("R4 base bits cleared", 40'h00_2000_0000, 4'd9, 3'd3, 1'b0, 6'd63, 6'd0);
        issue("R4 wide splice",  40'hE0_0000_0000, 4'd9, 3'd3, 1'b1, 6'd3, 6'd63);
        issue("R5 memunit",      40'hFF_FFFF_FFFF, 4'd7, 3'd0, 1'b1, 6'd1, 6'd2);
        issue("R5 regbus",       40'hFF_FFFF_FFFF, 4'd14, 3'd1, 1'b0, 6'd1, 6'd2);
        issue("R5 target 15 ok", 40'h00_8000_0000, 4'd15, 3'd1, 1'b0, 6'd1, 6'd2);
        issue("R6 mode 4",       40'hFF_FFFF_FFFF, 4'd0, 3'd4, 1'b0, 6'd9, 6'd9);
        issue("R6 mode 7",       40'hFF_FFFF_FFFF, 4'd0, 3'd7, 1'b1, 6'd9, 6'd9);

        // R9: inputs change without req; outputs must hold.
        issue("R9 setup", 40'h00_8000_0000, 4'd1, 3'd1, 1'b0, 6'd4, 6'd27);
        last = {err, island};
        for (int i = 0; i < 4; i++) begin
            addr = {$urandom, $urandom}; mode = 3'd0; base1 = 6'($urandom);
            @(negedge clk);
            check("R9 hold", {1'b0, err, island}, {1'b0, last});
            check("R7 no done when idle", {7'd0, done}, 8'd0);
        end

        // Random requests.
        for (int i = 0; i < 400; i++) begin
            logic [2:0] m = ($urandom % 10 < 8) ? 3'($urandom % 4) : 3'(4 + $urandom % 4);
            issue("R1-4 random decode (R5 R6 R8)", {$urandom, $urandom}, 4'($urandom), m,
                  1'($urandom), 6'($urandom), 6'($urandom));
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                check("R7 gap done low", {7'd0, done}, 8'd0);
            end
        end

        // R10: reset after a nonzero result.
        issue("R10 setup", 40'h00_0000_0000, 4'd0, 3'd1, 1'b0, 6'd50, 6'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset after use", {done, err, island}, 8'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule